// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block keeps the pending-interrupt state of a small parallel-interface peripheral. Three event sources (the shift engine, a first timer and a second timer) each send a one-cycle pulse that latches a bit in a 7-bit flag register. A 7-bit enable register selects which pending flags count as active. A single level-sensitive interrupt line goes high while an active flag belongs to the shift engine or the first timer. A pending, enabled second-timer flag is reported to software but never raises the line.

Software reaches both registers over a byte-wide bus. The register index is taken from address bits [12:9]. The flag register is index 13 and the enable register is index 14. A write to the flag register clears every flag whose data bit is 1. A write to the enable register uses data bit 7 to choose the action: when bit 7 is 1 the write sets enables, and when it is 0 the write clears them. A read of the shift data register (index 10) also acknowledges the shift flag. The shift data itself is supplied by another block, so this block returns zero for that read.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After synchronous reset the flag and enable registers are zero, the interrupt line is low, a flag read returns 0x00 and an enable read returns 0x80.
- R2: An enable write (index 14) with data bit 7 at 1 ORs data bits 6:0 into the enable register.
- R3: An enable write with data bit 7 at 0 clears every enable bit whose data bit is 1 and leaves the other enable bits unchanged.
- R4: An enable read always returns bit 7 as 1, with bits 6:0 holding the enables.
- R5: A pulse on the shift, second-timer or first-timer source sets flag bit 2, 5 or 6 respectively. The flag is visible in the cycle after the pulse, and several sources may pulse together.
- R6: A flag write (index 13) clears each flag whose data bit is 1 and leaves the other flags unchanged.
- R7: A flag read returns the flags in bits 6:0. Bit 7 is 1 exactly when some flag is also enabled, and this includes the second-timer flag.
- R8: The interrupt output is high exactly when a flag is set and enabled in bit 2 or bit 6 (mask 0x44). The second-timer flag never drives it.
- R9: A read at index 10 clears only the shift flag (bit 2).
- R10: When a source pulse and a clear (flag write or index-10 read) hit the same flag bit in one cycle, the bit ends up set.
- R11: Only address bits [12:9] select the register. Writes to any index other than 13 or 14 change neither register.
- R12: The read data is 0x00 unless a read strobe targets index 13 or 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 16 | Byte bus address; bits [12:9] select the register |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational from current state) |
| shift_set_i | input | 1 | Shift engine event pulse |
| t1_set_i | input | 1 | First timer event pulse |
| t2_set_i | input | 1 | Second timer event pulse |
| irq_o | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is a set pulse and a clear landing on the same flag in the same cycle. This happens both through a flag write and through the acknowledge side effect of reading the shift data register. The stimulus drives a source pulse in the same cycle as the bus strobe and then reads the flags back to confirm the bit survived. The relation between enable, flag and interrupt line is swept over all 128 enable patterns against all eight source combinations, and the second-timer-only case is checked to raise the read summary bit without raising the line.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
    localparam int FLAG_W = 7;
    localparam int IDX_W  = 4;

    typedef logic [FLAG_W-1:0] flag_vec_t;
    typedef logic [IDX_W-1:0]  reg_idx_t;

    localparam int BIT_SHIFT = 2;
    localparam int BIT_TMR2  = 5;
    localparam int BIT_TMR1  = 6;

    localparam reg_idx_t IDX_SHIFT_DATA = 4'd10;
    localparam reg_idx_t IDX_FLAGS      = 4'd13;
    localparam reg_idx_t IDX_ENABLES    = 4'd14;

    localparam flag_vec_t LINE_SRC_MASK = flag_vec_t'((1 << BIT_SHIFT) | (1 << BIT_TMR1));

    typedef struct packed {
        logic wr_flags;
        logic wr_enables;
        logic rd_flags;
        logic rd_enables;
        logic rd_shift;
    } reg_strobe_t;

    function automatic flag_vec_t source_vec(input logic sh, input logic t2, input logic t1);
        flag_vec_t v;
        v = '0;
        v[BIT_SHIFT] = sh;
        v[BIT_TMR2]  = t2;
        v[BIT_TMR1]  = t1;
        return v;
    endfunction
endpackage

// File: rtl/irqf_decode.sv
module irqf_decode
    import irqf_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int IDX_LSB = 9
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    output reg_strobe_t       strobe_o
);
    localparam int IDX_MSB = IDX_LSB + IDX_W - 1;

    reg_idx_t idx;
    assign idx = addr_i[IDX_MSB:IDX_LSB];

    always_comb begin
        strobe_o            = '0;
        strobe_o.wr_flags   = wr_i && (idx == IDX_FLAGS);
        strobe_o.wr_enables = wr_i && (idx == IDX_ENABLES);
        strobe_o.rd_flags   = rd_i && (idx == IDX_FLAGS);
        strobe_o.rd_enables = rd_i && (idx == IDX_ENABLES);
        strobe_o.rd_shift   = rd_i && (idx == IDX_SHIFT_DATA);
    end
endmodule

// File: rtl/irqf_flag_reg.sv
module irqf_flag_reg
    import irqf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flag_vec_t set_i,
    input  flag_vec_t clr_i,
    output flag_vec_t flags_o
);
    flag_vec_t flags_q;

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= (flags_q & ~clr_i) | set_i;
    end

    assign flags_o = flags_q;

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (set_i != '0) |=> ((flags_q & $past(set_i)) == $past(set_i)));

    assert_clear_only_R6: assert property (@(posedge clk) disable iff (rst)
        (clr_i != '0) |=> ((flags_q & $past(clr_i & ~set_i)) == '0));

    assert_untouched_hold_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flags_q & ~$past(clr_i | set_i)) == ($past(flags_q) & ~$past(clr_i | set_i))));
endmodule

// File: rtl/irqf_enable_reg.sv
module irqf_enable_reg
    import irqf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_i,
    input  logic [7:0] wdata_i,
    output flag_vec_t  enables_o
);
    flag_vec_t en_q;
    flag_vec_t bits;

    assign bits = wdata_i[FLAG_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (wr_i) begin
            if (wdata_i[7]) en_q <= en_q | bits;
            else            en_q <= en_q & ~bits;
        end
    end

    assign enables_o = en_q;

    assert_set_write_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_i && wdata_i[7]) |=> ((en_q & $past(bits)) == $past(bits)));

    assert_clr_write_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !wdata_i[7]) |=> ((en_q & $past(bits)) == '0));

    assert_no_write_stable_R11: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> $stable(en_q));
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irqf_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int IDX_LSB = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o,
    input  logic              shift_set_i,
    input  logic              t1_set_i,
    input  logic              t2_set_i,
    output logic              irq_o
);
    reg_strobe_t strobe;
    flag_vec_t   flags;
    flag_vec_t   enables;
    flag_vec_t   set_vec;
    flag_vec_t   clr_vec;
    flag_vec_t   active;
    logic        any_active;

    irqf_decode #(.ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB)) u_decode (
        .addr_i   (addr_i),
        .wr_i     (wr_i),
        .rd_i     (rd_i),
        .strobe_o (strobe)
    );

    assign set_vec = source_vec(shift_set_i, t2_set_i, t1_set_i);

    always_comb begin
        clr_vec = '0;
        if (strobe.wr_flags) clr_vec = wdata_i[FLAG_W-1:0];
        if (strobe.rd_shift) clr_vec[BIT_SHIFT] = 1'b1;
    end

    irqf_flag_reg u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_i   (set_vec),
        .clr_i   (clr_vec),
        .flags_o (flags)
    );

    irqf_enable_reg u_enables (
        .clk       (clk),
        .rst       (rst),
        .wr_i      (strobe.wr_enables),
        .wdata_i   (wdata_i),
        .enables_o (enables)
    );

    assign active     = flags & enables;
    assign any_active = |active;
    assign irq_o      = |(active & LINE_SRC_MASK);

    always_comb begin
        rdata_o = 8'h00;
        if (strobe.rd_flags)        rdata_o = {any_active, flags};
        else if (strobe.rd_enables) rdata_o = {1'b1, enables};
    end

    assert_t2_no_line_R8: assert property (@(posedge clk) disable iff (rst)
        ((flags & enables & ~flag_vec_t'(1 << BIT_TMR2)) == '0) |-> !irq_o);

    assert_shift_ack_R9: assert property (@(posedge clk) disable iff (rst)
        (strobe.rd_shift && !shift_set_i) |=> !flags[BIT_SHIFT]);

    always_comb begin
        if (!rst && strobe.rd_enables) begin
            assert_enable_msb_R4: assert (rdata_o[7]);
        end
        if (!rst && !rd_i) begin
            assert_idle_read_zero_R12: assert (rdata_o == 8'h00);
        end
    end
endmodule

// File: tb/tb_irq_flag_ctrl.sv
module tb_irq_flag_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr_i = '0;
    logic        wr_i = 1'b0;
    logic        rd_i = 1'b0;
    logic [7:0]  wdata_i = '0;
    logic [7:0]  rdata_o;
    logic        shift_set_i = 1'b0;
    logic        t1_set_i = 1'b0;
    logic        t2_set_i = 1'b0;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    int junk   = 0;
    logic [6:0] m_flags = '0;
    logic [6:0] m_en    = '0;
    logic [7:0] last_rd;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_flag_ctrl dut (
        .clk(clk), .rst(rst), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .shift_set_i(shift_set_i),
        .t1_set_i(t1_set_i), .t2_set_i(t2_set_i), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // One bus cycle with optional source pulses (src = {t1, t2, shift}); updates the model.
    task automatic cyc(input logic wr, input logic rd, input logic [3:0] idx,
                       input logic [7:0] d, input logic [2:0] src);
        logic [6:0] clr;
        logic [6:0] setv;
        @(negedge clk);
        junk = junk + 1;
        addr_i  = {junk[2:0], idx, junk[8:0] ^ 9'h0A5};
        wr_i = wr; rd_i = rd; wdata_i = d;
        shift_set_i = src[0]; t2_set_i = src[1]; t1_set_i = src[2];
        #1 last_rd = rdata_o;
        @(negedge clk);
        wr_i = 1'b0; rd_i = 1'b0; wdata_i = '0;
        shift_set_i = 1'b0; t2_set_i = 1'b0; t1_set_i = 1'b0;
        clr  = '0;
        setv = {src[2], src[1], 2'b00, src[0], 2'b00};
        if (wr && idx == 4'd13) clr = d[6:0];
        if (rd && idx == 4'd10) clr[2] = 1'b1;
        m_flags = (m_flags & ~clr) | setv;
        if (wr && idx == 4'd14) m_en = d[7] ? (m_en | d[6:0]) : (m_en & ~d[6:0]);
    endtask

    function automatic logic [7:0] exp_flag_rd();
        return {|(m_flags & m_en), m_flags};
    endfunction

    function automatic logic exp_irq();
        return |(m_flags & m_en & 7'h44);
    endfunction

    task automatic read_flags(input string req);
        cyc(1'b0, 1'b1, 4'd13, 8'h00, 3'b000);
        check(req, last_rd, exp_flag_rd());
    endtask

    task automatic read_enables(input string req);
        cyc(1'b0, 1'b1, 4'd14, 8'h00, 3'b000);
        check(req, last_rd, {1'b1, m_en});
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1 reset state
        check("R1 irq", {7'b0, irq_o}, 8'h00);
        read_flags("R1 flags");
        read_enables("R1 enables");

        // R2/R3/R4/R5/R7/R8 sweep over all enable patterns and source mixes
        for (int e = 0; e < 128; e++) begin
            cyc(1'b1, 1'b0, 4'd14, 8'h7F, 3'b000);          // R3 clear all
            cyc(1'b1, 1'b0, 4'd14, 8'h80 | 8'(e), 3'b000);  // R2 set pattern
            read_enables("R2 R4 enable readback");
            for (int s = 0; s < 8; s++) begin
                cyc(1'b0, 1'b0, 4'd0, 8'h00, 3'(s));        // R5 pulse
                check("R8 irq", {7'b0, irq_o}, {7'b0, exp_irq()});
                read_flags("R5 R7 flag readback");
                cyc(1'b1, 1'b0, 4'd13, 8'h7F, 3'b000);      // R6 clear all
                read_flags("R6 flags cleared");
            end
        end

        // R6 partial clear
        cyc(1'b1, 1'b0, 4'd14, 8'hFF, 3'b000);
        cyc(1'b0, 1'b0, 4'd0, 8'h00, 3'b111);
        cyc(1'b1, 1'b0, 4'd13, 8'h20, 3'b000);
        check("R6 partial", {1'b1, m_flags}, 8'hC4);
        read_flags("R6 partial readback");

        // R3 partial clear of enables
        cyc(1'b1, 1'b0, 4'd14, 8'h04, 3'b000);
        read_enables("R3 partial");
        check("R3 value", {1'b1, m_en}, 8'hFB);

        // R9 shift ack and R12 zero read data
        cyc(1'b0, 1'b0, 4'd0, 8'h00, 3'b111);
        cyc(1'b0, 1'b1, 4'd10, 8'h00, 3'b000);
        check("R12 index10 data", last_rd, 8'h00);
        read_flags("R9 shift acked");
        check("R9 model", {1'b0, m_flags}, 8'h60);

        // R10 set beats clear
        cyc(1'b1, 1'b0, 4'd13, 8'h7F, 3'b111);
        read_flags("R10 write clear vs set");
        check("R10 value", {1'b0, m_flags}, 8'h64);
        cyc(1'b0, 1'b1, 4'd10, 8'h00, 3'b001);
        read_flags("R10 ack vs shift set");

        // R11 other indices have no effect; R12 read of other index
        cyc(1'b1, 1'b0, 4'd12, 8'hFF, 3'b000);
        cyc(1'b1, 1'b0, 4'd15, 8'h7F, 3'b000);
        read_flags("R11 flags untouched");
        read_enables("R11 enables untouched");
        cyc(1'b0, 1'b1, 4'd3, 8'h00, 3'b000);
        check("R12 other index", last_rd, 8'h00);

        // R7/R8 timer-2 only: summary bit set, line low
        cyc(1'b1, 1'b0, 4'd13, 8'h7F, 3'b000);
        cyc(1'b1, 1'b0, 4'd14, 8'hFF, 3'b000);
        cyc(1'b0, 1'b0, 4'd0, 8'h00, 3'b010);
        check("R8 t2 no irq", {7'b0, irq_o}, 8'h00);
        read_flags("R7 t2 summary");

        // R1 reset again clears everything
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        m_flags = '0; m_en = '0;
        read_flags("R1 re-reset flags");
        read_enables("R1 re-reset enables");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule